// File: doc/BRIEF.md
# Limit-Compare Interrupt Controller with Rearm Delay

This block watches a stream of measurement results and raises an active-low interrupt when any measured value leaves its allowed window. Each result arrives with a channel index, an unsigned value and a flag that marks it as a local-temperature reading. The block holds a high and a low limit for every channel. On each result it rewrites that channel's status bit from the comparison. Per-channel mask bits decide which status bits can set a shared interrupt latch.

The latch output is combined with two external interrupt sources, a fan alarm and a general-purpose input alarm, to drive the interrupt pin. When software clears the interrupt, the latch is reset and held off until two more local-temperature results have arrived. The external sources can still pull the pin during that hold-off. Limits and masks are written through a simple per-channel write port, and the status bits are visible on an output vector.

Top module: `limit_irq_ctrl`

## Requirements
- R1: A result is out of limit when its value is strictly greater than the channel's high limit; a value equal to the high limit is in limit.
- R2: A result is out of limit when its value is less than or equal to the channel's low limit.
- R3: Each result rewrites only its own channel's status bit, on the clock edge where `measValid` is sampled: 1 when out of limit, 0 when in limit. The status bits of other channels are unchanged.
- R4: A status bit whose mask bit is 1 cannot set the interrupt latch. Clearing the mask bit while the status bit is 1 sets the latch one cycle after the mask write.
- R5: When any unmasked status bit is 1 and the latch is armed, the latch sets on the next clock edge. It stays set until a clear, even if the status bits return to 0.
- R6: `intN` is 0 exactly when the latch, `fanIrq` or `gpioIrq` is 1. The external inputs act on `intN` without a clock delay.
- R7: An `intClr` pulse resets the latch on that edge and wins over a simultaneous set. The status bits are left unchanged.
- R8: After a clear, the latch cannot set until two results with `measLocal`=1 have been sampled. Results with `measLocal`=0 do not count. If an unmasked status bit is still 1, the latch sets on the edge after the second local result.
- R9: During the hold-off window, `fanIrq` and `gpioIrq` still drive `intN` low.
- R10: After reset, all limits, masks and status bits are 0 and the latch is clear and armed. With zero limits, any non-zero value exceeds the high limit.
- R11: The `cfgWrKind` encoding is as follows. 0 writes the high limit from `cfgWrData`, 1 writes the low limit, and 2 writes the mask bit from `cfgWrData[0]`. Each write goes to channel `cfgWrChan`. Kind 3 changes nothing.
- R12: A clear issued during the hold-off window restarts the count, so two further local results are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| measValid | input | 1 | A measurement result is present this cycle |
| measChan | input | 4 | Channel index of the result |
| measValue | input | 8 | Unsigned measured value |
| measLocal | input | 1 | Result is a local-temperature measurement |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrKind | input | 2 | 0 high limit, 1 low limit, 2 mask, 3 none |
| cfgWrChan | input | 4 | Channel targeted by the write |
| cfgWrData | input | 8 | Write data (bit 0 for a mask write) |
| intClr | input | 1 | Single-cycle interrupt clear |
| fanIrq | input | 1 | External fan interrupt, active high |
| gpioIrq | input | 1 | External general-purpose interrupt, active high |
| statusOut | output | 16 | Per-channel out-of-limit status |
| intN | output | 1 | Interrupt pin, active low |

## Verification
A wrong comparison or a status bit written to the wrong channel appears on `statusOut` in the cycle right after the result is sampled. A stale or wrongly gated latch appears on `intN` one cycle after the status change. A rearm counter that is off by one shows as `intN` dropping one local result too early or too late after a clear. The bench therefore follows every clear with a sequence of local, non-local and repeated-clear results, and checks the pin cycle by cycle.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    CFG_HIGH = 2'd0,
    CFG_LOW  = 2'd1,
    CFG_MASK = 2'd2,
    CFG_NONE = 2'd3
  } cfg_kind_e;

  typedef struct packed {
    logic statusWr;
    logic cfgWr;
  } lic_strobe_t;
endpackage

// File: rtl/lic_datapath.sv
module lic_datapath
  import lic_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int VAL_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lic_strobe_t       stb,
  input  logic [CH_W-1:0]   measChan,
  input  logic [VAL_W-1:0]  measValue,
  input  logic [1:0]        cfgWrKind,
  input  logic [CH_W-1:0]   cfgWrChan,
  input  logic [VAL_W-1:0]  cfgWrData,
  output logic [NUM_CH-1:0] statusOut,
  output logic              anyUnmasked
);
  logic [NUM_CH-1:0] maskVec;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [VAL_W-1:0] hiQ, loQ;
    logic             maskQ, statQ;
    logic             hitMe, cfgMe, outLim;

    assign hitMe  = stb.statusWr && (measChan == CH_W'(g));
    assign cfgMe  = stb.cfgWr && (cfgWrChan == CH_W'(g));
    assign outLim = (measValue > hiQ) || (measValue <= loQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiQ   <= '0;
        loQ   <= '0;
        maskQ <= 1'b0;
        statQ <= 1'b0;
      end else begin
        if (cfgMe) begin
          case (cfg_kind_e'(cfgWrKind))
            CFG_HIGH: hiQ   <= cfgWrData;
            CFG_LOW:  loQ   <= cfgWrData;
            CFG_MASK: maskQ <= cfgWrData[0];
            default:  ;
          endcase
        end
        if (hitMe) statQ <= outLim;
      end
    end

    assign statusOut[g] = statQ;
    assign maskVec[g]   = maskQ;

    // R1
    high_cmp_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hitMe && measValue > hiQ) |=> statQ);
    // R2
    low_cmp_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hitMe && measValue <= loQ) |=> statQ);
  end

  assign anyUnmasked = |(statusOut & ~maskVec);

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.statusWr |=> $stable(statusOut));
  // R3
  one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.statusWr |=> ($countones(statusOut ^ $past(statusOut)) <= 1));
endmodule

// File: rtl/lic_control.sv
module lic_control
  import lic_pkg::*;
#(
  parameter int REARM_COUNT = 2,
  localparam int CNT_W = $clog2(REARM_COUNT + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        measValid,
  input  logic        measLocal,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgWrKind,
  input  logic        intClr,
  input  logic        anyUnmasked,
  input  logic        fanIrq,
  input  logic        gpioIrq,
  output lic_strobe_t stb,
  output logic        intN
);
  logic             latchQ, blockedQ;
  logic [CNT_W-1:0] cntQ;
  logic             localTick;

  assign localTick    = measValid && measLocal;
  assign stb.statusWr = measValid;
  assign stb.cfgWr    = cfgWrEn && (cfg_kind_e'(cfgWrKind) != CFG_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ   <= 1'b0;
      blockedQ <= 1'b0;
      cntQ     <= '0;
    end else if (intClr) begin
      latchQ   <= 1'b0;
      blockedQ <= 1'b1;
      cntQ     <= '0;
    end else begin
      if (anyUnmasked && !blockedQ) latchQ <= 1'b1;
      if (blockedQ && localTick) begin
        if (cntQ == CNT_W'(REARM_COUNT - 1)) begin
          blockedQ <= 1'b0;
          cntQ     <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign intN = ~(latchQ | fanIrq | gpioIrq);

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    intClr |=> !latchQ);
  // R8
  rearm_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchQ) |-> $past(!blockedQ));
  // R8
  block_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockedQ && !localTick && !intClr) |=> blockedQ);
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && !intClr) |=> latchQ);
  // R12
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < CNT_W'(REARM_COUNT));
endmodule

// File: rtl/limit_irq_ctrl.sv
module limit_irq_ctrl
  import lic_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int VAL_W       = 8,
  parameter int REARM_COUNT = 2,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              measValid,
  input  logic [CH_W-1:0]   measChan,
  input  logic [VAL_W-1:0]  measValue,
  input  logic              measLocal,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrKind,
  input  logic [CH_W-1:0]   cfgWrChan,
  input  logic [VAL_W-1:0]  cfgWrData,
  input  logic              intClr,
  input  logic              fanIrq,
  input  logic              gpioIrq,
  output logic [NUM_CH-1:0] statusOut,
  output logic              intN
);
  lic_strobe_t stb;
  logic        anyUnmasked;

  lic_control #(.REARM_COUNT(REARM_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .measValid(measValid), .measLocal(measLocal),
    .cfgWrEn(cfgWrEn), .cfgWrKind(cfgWrKind), .intClr(intClr),
    .anyUnmasked(anyUnmasked), .fanIrq(fanIrq), .gpioIrq(gpioIrq),
    .stb(stb), .intN(intN)
  );

  lic_datapath #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .measChan(measChan),
    .measValue(measValue), .cfgWrKind(cfgWrKind), .cfgWrChan(cfgWrChan),
    .cfgWrData(cfgWrData), .statusOut(statusOut), .anyUnmasked(anyUnmasked)
  );
endmodule

// File: tb/limit_irq_ctrl_bench.sv
module limit_irq_ctrl_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic measValid = 0, measLocal = 0, cfgWrEn = 0, intClr = 0, fanIrq = 0, gpioIrq = 0;
  logic [3:0] measChan = '0, cfgWrChan = '0;
  logic [7:0] measValue = '0, cfgWrData = '0;
  logic [1:0] cfgWrKind = '0;
  logic [15:0] statusOut;
  logic intN;

  int runCnt = 0, failCnt = 0;
  logic [7:0] bHi [16];
  logic [7:0] bLo [16];
  logic [15:0] bMask = '0, expStat = '0;

  always #10 clk = ~clk;

  limit_irq_ctrl u_limit_irq_ctrl (
    .clk(clk), .rstN(rstN), .measValid(measValid), .measChan(measChan),
    .measValue(measValue), .measLocal(measLocal), .cfgWrEn(cfgWrEn),
    .cfgWrKind(cfgWrKind), .cfgWrChan(cfgWrChan), .cfgWrData(cfgWrData),
    .intClr(intClr), .fanIrq(fanIrq), .gpioIrq(gpioIrq),
    .statusOut(statusOut), .intN(intN)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfgWrite(logic [1:0] kind, logic [3:0] ch, logic [7:0] d);
    cfgWrEn = 1; cfgWrKind = kind; cfgWrChan = ch; cfgWrData = d;
    tick();
    cfgWrEn = 0;
    case (kind)
      2'd0: bHi[ch] = d;
      2'd1: bLo[ch] = d;
      2'd2: bMask[ch] = d[0];
      default: ;
    endcase
  endtask

  // R3: status vector checked against bench model after every result
  task automatic meas(logic [3:0] ch, logic [7:0] v, logic loc);
    measValid = 1; measChan = ch; measValue = v; measLocal = loc;
    tick();
    measValid = 0; measLocal = 0;
    expStat[ch] = (v > bHi[ch]) || (v <= bLo[ch]);
    check("R3 status", statusOut, expStat);
  endtask

  task automatic pulseClr();
    intClr = 1; tick(); intClr = 0;
    check("R7 clear drops pin", {15'd0, intN}, 16'd1);
    check("R7 status kept", statusOut, expStat);
  endtask

  task automatic testReset();
    check("R10 status zero", statusOut, 16'd0);
    check("R10 pin idle", {15'd0, intN}, 16'd1);
    meas(1, 8'd1, 0);
    check("R10 zero high limit exceeded", {15'd0, statusOut[1]}, 16'd1);
    check("R5 pin not yet", {15'd0, intN}, 16'd1);
    tick();
    check("R10 armed at reset", {15'd0, intN}, 16'd0);
    pulseClr();
  endtask

  task automatic testConfig();
    for (int c = 0; c < 16; c++) begin
      cfgWrite(2'd0, 4'(c), 8'd200);
      cfgWrite(2'd1, 4'(c), 8'd50);
    end
    cfgWrite(2'd3, 4'd3, 8'd0);
    meas(1, 8'd100, 0);
    meas(3, 8'd150, 0);
    check("R11 kind3 no effect", {15'd0, statusOut[3]}, 16'd0);
    meas(0, 8'd100, 1);
    meas(0, 8'd100, 1);
    tick();
    check("R8 rearmed idle", {15'd0, intN}, 16'd1);
  endtask

  task automatic testHigh();
    meas(3, 8'd200, 0);
    check("R1 equal in limit", {15'd0, statusOut[3]}, 16'd0);
    meas(3, 8'd201, 0);
    check("R1 above high", {15'd0, statusOut[3]}, 16'd1);
    check("R5 one cycle later", {15'd0, intN}, 16'd1);
    tick();
    check("R5 latch set", {15'd0, intN}, 16'd0);
    meas(3, 8'd100, 0);
    check("R3 self clear", {15'd0, statusOut[3]}, 16'd0);
    check("R5 latch held", {15'd0, intN}, 16'd0);
  endtask

  task automatic testRearm();
    meas(5, 8'd10, 0);
    pulseClr();
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R8 blocked idle", {15'd0, intN}, 16'd1);
    end
    meas(5, 8'd10, 0);
    check("R8 nonlocal not counted", {15'd0, intN}, 16'd1);
    meas(0, 8'd100, 1);
    tick();
    check("R8 one local", {15'd0, intN}, 16'd1);
    meas(0, 8'd100, 1);
    check("R8 second local edge", {15'd0, intN}, 16'd1);
    tick();
    check("R8 rearm sets", {15'd0, intN}, 16'd0);
  endtask

  task automatic testLow();
    pulseClr();
    meas(6, 8'd51, 0);
    check("R2 above low", {15'd0, statusOut[6]}, 16'd0);
    meas(6, 8'd50, 0);
    check("R2 equal low", {15'd0, statusOut[6]}, 16'd1);
  endtask

  task automatic testExt();
    fanIrq = 1; #1;
    check("R9 fan in window", {15'd0, intN}, 16'd0);
    fanIrq = 0; #1;
    check("R6 fan release", {15'd0, intN}, 16'd1);
    gpioIrq = 1; #1;
    check("R9 gpio in window", {15'd0, intN}, 16'd0);
    gpioIrq = 0; #1;
    check("R6 gpio release", {15'd0, intN}, 16'd1);
    @(negedge clk);
  endtask

  task automatic testRestart();
    meas(0, 8'd100, 1);
    pulseClr();
    meas(0, 8'd100, 1);
    tick();
    check("R12 count restarted", {15'd0, intN}, 16'd1);
    meas(0, 8'd100, 1);
    tick();
    check("R12 rearm after two", {15'd0, intN}, 16'd0);
  endtask

  task automatic testMask();
    meas(5, 8'd100, 0);
    meas(6, 8'd100, 0);
    pulseClr();
    meas(0, 8'd100, 1);
    meas(0, 8'd100, 1);
    tick();
    check("R8 rearmed clean", {15'd0, intN}, 16'd1);
    cfgWrite(2'd2, 4'd7, 8'd1);
    meas(7, 8'd255, 0);
    tick(); tick();
    check("R4 masked", {15'd0, intN}, 16'd1);
    cfgWrite(2'd2, 4'd7, 8'd0);
    check("R4 unmask edge", {15'd0, intN}, 16'd1);
    tick();
    check("R4 unmask sets", {15'd0, intN}, 16'd0);
  endtask

  initial begin
    for (int c = 0; c < 16; c++) begin bHi[c] = 0; bLo[c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testConfig();
    testHigh();
    testRearm();
    testLow();
    testExt();
    testRestart();
    testMask();
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    #(200000 * 20);
    runCnt++; failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule